// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block is the interrupt controller for a single processor. It serves 32 interrupt IDs. IDs 0 to 15 are raised only by software. IDs 16 to 31 follow external request lines. Software programs the controller over a word-wide register bus, which has an address, write data, a write strobe, a read strobe and registered read data. Software uses this bus to set and clear enables, force IDs pending, choose each ID's group and trigger type, and give each ID a priority. It also sets a priority mask and a preemption split. Each ID is routed to one of two outputs by its group: group 0 drives the fast interrupt line and group 1 drives the normal interrupt line.

A handler reads the acknowledge register. The read returns the most urgent eligible ID and makes that ID active. If no ID is eligible, the read returns 1023. When the handler finishes, it writes the same ID to the end-of-interrupt register, which clears the active state. The most urgent active ID sets the running priority. A new request is signalled only when it beats the running priority in the priority bits selected by the preemption split.

Top module: `irqc_top`

## Requirements
- R1: After reset both outputs are low, an acknowledge read returns 1023 and the enable register reads 0x0000FFFF.
- R2: Writing a 1 to a bit of the enable-set word (address 1) enables that ID, and writing a 1 to a bit of the enable-clear word (address 2) disables it. Zero bits leave the enables unchanged. Both addresses read back the enable bits.
- R3: Enable bits 0 to 15 always read as 1, and clear-enable writes to those bits have no effect.
- R4: Writing a 1 to a bit of the pending-set word (address 3) makes that ID pending.
- R5: An acknowledge read (address 18) returns the pending, enabled, inactive ID with the smallest priority value. Priorities are one byte per ID, four IDs to a word at addresses 8 to 15, with the lowest ID in the low byte. When priority values are equal, the lowest ID wins.
- R6: Only IDs whose priority value is strictly below the mask (address 16) can be acknowledged or signalled. If no ID qualifies, the read returns 1023.
- R7: Group bit 0 routes an ID to fiq_o and group bit 1 routes it to irq_o (group word at address 4). Control bit 0 enables group 0 and control bit 1 enables group 1 (address 0). Each output is registered.
- R8: For line i (ID 16+i), setting bit 2i+1 of the trigger word (address 5) selects rising-edge detection. An acknowledge clears the pending state, and a line that stays high does not pend again.
- R9: When bit 2i+1 of the trigger word is 0 (level mode, reset value 0x55555555), the ID stays pending for as long as its line is high. It can be acknowledged again after the end-of-interrupt write.
- R10: With a preemption split n from 0 to 6 (address 17), a new request is signalled during an active interrupt only if priority bits 7 down to n+1 are strictly smaller than those of the running priority.
- R11: With a preemption split of 7, no request is signalled while any ID is active.
- R12: Writing an ID to the end-of-interrupt word (address 19) ends its active state. A request of equal priority that was held back is then signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; an acknowledge read has side effects |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq_lines | input | 16 | Request lines for IDs 16 to 31 |
| irq_o | output | 1 | Group 1 interrupt request |
| fiq_o | output | 1 | Group 0 interrupt request |

## Verification
The hardest state to reach is a nested one. An interrupt must be active while a second request sits pending with a priority that differs from the running priority only in the bits the preemption split discards. The stimulus acknowledges a low-urgency software ID first and then forces a more urgent one pending. It checks that the acknowledge read returns 1023 under one split setting. It then narrows the split and checks that the same request is now returned, without any change to the pending state. A second hard case is a level line held high across an acknowledge and end-of-interrupt pair, contrasted with an edge line held high across the same pair.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W   = 32;
  localparam int PRIO_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int SPURIOUS = 1023;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 5'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 5'd2;
  localparam logic [ADDR_W-1:0] A_PSET  = 5'd3;
  localparam logic [ADDR_W-1:0] A_GRP   = 5'd4;
  localparam logic [ADDR_W-1:0] A_TRIG  = 5'd5;
  localparam logic [ADDR_W-1:0] A_PRIO  = 5'd8;
  localparam logic [ADDR_W-1:0] A_PMASK = 5'd16;
  localparam logic [ADDR_W-1:0] A_SPLIT = 5'd17;
  localparam logic [ADDR_W-1:0] A_ACK   = 5'd18;
  localparam logic [ADDR_W-1:0] A_EOI   = 5'd19;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SGI   = 16,
  parameter int NUM_LINES = 16,
  localparam int NUM_IDS  = NUM_SGI + NUM_LINES,
  localparam int ID_W     = $clog2(NUM_IDS),
  localparam int NPW      = NUM_IDS / 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  input  logic                             bus_wr,
  input  logic [NUM_IDS-1:0]               pend_eff,
  output logic [1:0]                       grp_en,
  output logic [NUM_IDS-1:0]               id_en,
  output logic [NUM_IDS-1:0]               id_grp,
  output logic [NUM_LINES-1:0]             line_edge,
  output logic [NUM_IDS-1:0][PRIO_W-1:0]   id_prio,
  output logic [PRIO_W-1:0]                pmask,
  output logic [2:0]                       split,
  output logic [NUM_IDS-1:0]               pset,
  output logic                             eoi_fire,
  output logic [ID_W-1:0]                  eoi_id,
  output logic [DATA_W-1:0]                cfg_rdata
);
  logic [NUM_LINES-1:0]   line_en;
  logic [2*NUM_LINES-1:0] trig;

  always_comb begin
    id_en = {line_en, {NUM_SGI{1'b1}}};
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
      assign line_edge[i] = trig[2*i+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_en  <= '0;
      line_en <= '0;
      id_grp  <= '0;
      trig    <= {NUM_LINES{2'b01}};
      id_prio <= '0;
      pmask   <= '0;
      split   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  grp_en  <= bus_wdata[1:0];
        A_ENSET: line_en <= line_en | bus_wdata[NUM_IDS-1:NUM_SGI];
        A_ENCLR: line_en <= line_en & ~bus_wdata[NUM_IDS-1:NUM_SGI];
        A_GRP:   id_grp  <= bus_wdata[NUM_IDS-1:0];
        A_TRIG:  trig    <= bus_wdata[2*NUM_LINES-1:0];
        A_PMASK: pmask   <= bus_wdata[PRIO_W-1:0];
        A_SPLIT: split   <= bus_wdata[2:0];
        default: ;
      endcase
      for (int w = 0; w < NPW; w++) begin
        if (bus_addr == A_PRIO + ADDR_W'(w)) begin
          for (int b = 0; b < 4; b++) begin
            id_prio[4*w+b] <= bus_wdata[PRIO_W*b +: PRIO_W];
          end
        end
      end
    end
  end

  always_comb begin
    pset     = (bus_wr && bus_addr == A_PSET) ? bus_wdata[NUM_IDS-1:0] : '0;
    eoi_fire = bus_wr && bus_addr == A_EOI &&
               (bus_wdata[DATA_W-1:ID_W] == '0);
    eoi_id   = bus_wdata[ID_W-1:0];
  end

  always_comb begin
    cfg_rdata = '0;
    case (bus_addr)
      A_CTRL:  cfg_rdata = DATA_W'(grp_en);
      A_ENSET: cfg_rdata = DATA_W'(id_en);
      A_ENCLR: cfg_rdata = DATA_W'(id_en);
      A_PSET:  cfg_rdata = DATA_W'(pend_eff);
      A_GRP:   cfg_rdata = DATA_W'(id_grp);
      A_TRIG:  cfg_rdata = DATA_W'(trig);
      A_PMASK: cfg_rdata = DATA_W'(pmask);
      A_SPLIT: cfg_rdata = DATA_W'(split);
      default: ;
    endcase
    for (int w = 0; w < NPW; w++) begin
      if (bus_addr == A_PRIO + ADDR_W'(w)) begin
        cfg_rdata = {id_prio[4*w+3], id_prio[4*w+2], id_prio[4*w+1], id_prio[4*w]};
      end
    end
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int NUM_SGI   = 16,
  parameter int NUM_LINES = 16,
  localparam int NUM_IDS  = NUM_SGI + NUM_LINES,
  localparam int ID_W     = $clog2(NUM_IDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_LINES-1:0] line_edge,
  input  logic [NUM_IDS-1:0]   pset,
  input  logic                 ack_fire,
  input  logic [ID_W-1:0]      ack_id,
  input  logic                 eoi_fire,
  input  logic [ID_W-1:0]      eoi_id,
  output logic [NUM_IDS-1:0]   pend_eff,
  output logic [NUM_IDS-1:0]   active
);
  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] line_d;
  logic [NUM_IDS-1:0]   latch;
  logic [NUM_IDS-1:0]   hw_set;
  logic [NUM_IDS-1:0]   level_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      line_d <= '0;
    end else begin
      line_q <= irq_lines;
      line_d <= line_q;
    end
  end

  generate
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      if (i < NUM_SGI) begin : g_sw
        assign hw_set[i]     = 1'b0;
        assign level_hold[i] = 1'b0;
      end else begin : g_hw
        assign hw_set[i]     = line_edge[i-NUM_SGI] &
                               line_q[i-NUM_SGI] & ~line_d[i-NUM_SGI];
        assign level_hold[i] = ~line_edge[i-NUM_SGI] & line_q[i-NUM_SGI];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          latch[i]  <= 1'b0;
          active[i] <= 1'b0;
        end else begin
          if (ack_fire && ack_id == ID_W'(i)) latch[i] <= 1'b0;
          else if (pset[i] || hw_set[i])      latch[i] <= 1'b1;

          if (ack_fire && ack_id == ID_W'(i))      active[i] <= 1'b1;
          else if (eoi_fire && eoi_id == ID_W'(i)) active[i] <= 1'b0;
        end
      end

      assign pend_eff[i] = latch[i] | level_hold[i];
    end
  endgenerate
endmodule

// File: rtl/irqc_sel.sv
module irqc_sel
  import irqc_pkg::*;
#(
  parameter int NUM_IDS = 32,
  localparam int ID_W   = $clog2(NUM_IDS)
) (
  input  logic [NUM_IDS-1:0]             pend_eff,
  input  logic [NUM_IDS-1:0]             active,
  input  logic [NUM_IDS-1:0]             id_en,
  input  logic [NUM_IDS-1:0]             id_grp,
  input  logic [1:0]                     grp_en,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] id_prio,
  input  logic [PRIO_W-1:0]              pmask,
  input  logic [2:0]                     split,
  output logic                           win_valid,
  output logic [ID_W-1:0]                win_id,
  output logic                           win_grp
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic              any_act;
  logic [PRIO_W-1:0] run_p;
  logic [PRIO_W-1:0] gmask;
  logic              preempt_ok;
  logic [NUM_IDS-1:0] cand;

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) begin
      cand[i] = pend_eff[i] & id_en[i] & ~active[i] &
                grp_en[id_grp[i]] & (id_prio[i] < pmask);
    end
  end

  always_comb begin
    found  = 1'b0;
    best_p = '1;
    win_id = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cand[i] && (!found || id_prio[i] < best_p)) begin
        found  = 1'b1;
        best_p = id_prio[i];
        win_id = ID_W'(i);
      end
    end
  end

  always_comb begin
    any_act = |active;
    run_p   = '1;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (active[i] && id_prio[i] < run_p) run_p = id_prio[i];
    end
  end

  always_comb begin
    gmask      = {PRIO_W{1'b1}} << ({1'b0, split} + 4'd1);
    preempt_ok = !any_act ||
                 (split != 3'd7 && (best_p & gmask) < (run_p & gmask));
    win_valid  = found && preempt_ok;
    win_grp    = id_grp[win_id];
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SGI   = 16,
  parameter int NUM_LINES = 16,
  localparam int NUM_IDS  = NUM_SGI + NUM_LINES,
  localparam int ID_W     = $clog2(NUM_IDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_o,
  output logic                 fiq_o
);
  logic [1:0]                     grp_en;
  logic [NUM_IDS-1:0]             id_en;
  logic [NUM_IDS-1:0]             id_grp;
  logic [NUM_LINES-1:0]           line_edge;
  logic [NUM_IDS-1:0][PRIO_W-1:0] id_prio;
  logic [PRIO_W-1:0]              pmask;
  logic [2:0]                     split;
  logic [NUM_IDS-1:0]             pset;
  logic                           eoi_fire;
  logic [ID_W-1:0]                eoi_id;
  logic [DATA_W-1:0]              cfg_rdata;
  logic [NUM_IDS-1:0]             pend_eff;
  logic [NUM_IDS-1:0]             active;
  logic                           win_valid;
  logic [ID_W-1:0]                win_id;
  logic                           win_grp;
  logic                           ack_rd;
  logic                           ack_fire;

  irqc_regs #(.NUM_SGI(NUM_SGI), .NUM_LINES(NUM_LINES)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .pend_eff(pend_eff), .grp_en(grp_en), .id_en(id_en),
    .id_grp(id_grp), .line_edge(line_edge), .id_prio(id_prio),
    .pmask(pmask), .split(split), .pset(pset), .eoi_fire(eoi_fire),
    .eoi_id(eoi_id), .cfg_rdata(cfg_rdata)
  );

  irqc_pend #(.NUM_SGI(NUM_SGI), .NUM_LINES(NUM_LINES)) pend_i (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .line_edge(line_edge),
    .pset(pset), .ack_fire(ack_fire), .ack_id(win_id),
    .eoi_fire(eoi_fire), .eoi_id(eoi_id), .pend_eff(pend_eff),
    .active(active)
  );

  irqc_sel #(.NUM_IDS(NUM_IDS)) sel_i (
    .pend_eff(pend_eff), .active(active), .id_en(id_en), .id_grp(id_grp),
    .grp_en(grp_en), .id_prio(id_prio), .pmask(pmask), .split(split),
    .win_valid(win_valid), .win_id(win_id), .win_grp(win_grp)
  );

  always_comb begin
    ack_rd   = bus_rd && bus_addr == A_ACK;
    ack_fire = ack_rd && win_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (ack_rd)      bus_rdata <= win_valid ? DATA_W'(win_id) : DATA_W'(SPURIOUS);
      else if (bus_rd) bus_rdata <= cfg_rdata;
      irq_o <= win_valid &  win_grp;
      fiq_o <= win_valid & ~win_grp;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NUM_IDS = 32
) (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        irq_o,
  input logic        fiq_o
);
  assert_one_output_R7: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && fiq_o));

  assert_ack_range_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_ACK) |=>
      (bus_rdata < NUM_IDS || bus_rdata == SPURIOUS));

  assert_sgi_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_ENSET || bus_addr == A_ENCLR)) |=>
      (bus_rdata[15:0] == 16'hFFFF));

  assert_groups_off_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL && bus_wdata == 32'd0) |=> ##1
      (!irq_o && !fiq_o));
endmodule

bind irqc_top irqc_chk #(.NUM_IDS(NUM_IDS)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines = '0;
  logic        irq_o;
  logic        fiq_o;

  int n_run  = 0;
  int n_fail = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // monitor: compare each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %0d (0x%08h) expected %0d (0x%08h)",
                 t, bus_rdata, bus_rdata, e, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pins(input logic ei, input logic ef, input string t);
    n_run++;
    if (irq_o !== ei || fiq_o !== ef) begin
      n_fail++;
      $display("FAIL %s: irq/fiq got %b/%b expected %b/%b", t, irq_o, fiq_o, ei, ef);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] NONE = 32'd1023;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    pins(1'b0, 1'b0, "R1 reset outputs");
    rd(5'd18, NONE, "R1 reset ack");
    rd(5'd1, 32'h0000FFFF, "R1 reset enables");

    // R2 set/clear enable, R3 SGI enables fixed
    wr(5'd1, 32'h000A0000);
    rd(5'd1, 32'h000AFFFF, "R2 set enable");
    wr(5'd1, 32'h0);
    rd(5'd2, 32'h000AFFFF, "R2 zero write no effect");
    wr(5'd2, 32'h00020000);
    rd(5'd1, 32'h0008FFFF, "R2 clear enable");
    wr(5'd2, 32'h0000FFFF);
    rd(5'd1, 32'h0008FFFF, "R3 SGI clear ignored");
    wr(5'd2, 32'h00080000);
    rd(5'd1, 32'h0000FFFF, "R2 clear back");

    // common setup
    wr(5'd16, 32'hFF);
    wr(5'd0, 32'h3);
    for (int w = 0; w < 8; w++) wr(5'(8 + w), 32'h80808080);
    rd(5'd9, 32'h80808080, "R5 priority readback");
    wr(5'd2, 32'h0000FFFF);
    // R3: SGI still acknowledged after clear-enable attempt
    wr(5'd3, 32'h00000001);
    rd(5'd18, 32'd0, "R3 SGI still enabled");
    wr(5'd19, 32'd0);

    // R4, R5 tie, R12
    wr(5'd3, 32'h00000028);
    rd(5'd3, 32'h00000028, "R4 pending readback");
    rd(5'd18, 32'd3, "R5 tie lowest id");
    rd(5'd18, NONE, "R12 equal priority held");
    wr(5'd19, 32'd3);
    rd(5'd18, 32'd5, "R12 after end of interrupt");
    wr(5'd19, 32'd5);
    rd(5'd18, NONE, "R4 nothing pending");

    // R5 priority order
    wr(5'd9, 32'h80408080);
    wr(5'd3, 32'h00000044);
    rd(5'd18, 32'd6, "R5 lower value wins");
    wr(5'd19, 32'd6);
    rd(5'd18, 32'd2, "R5 next");
    wr(5'd19, 32'd2);

    // R6 mask
    wr(5'd16, 32'h40);
    wr(5'd3, 32'h00000040);
    rd(5'd18, NONE, "R6 masked equal");
    wr(5'd16, 32'h41);
    rd(5'd18, 32'd6, "R6 beats mask");
    wr(5'd19, 32'd6);
    wr(5'd16, 32'hFF);

    // R7 group routing
    wr(5'd3, 32'h00000002);
    idle(2);
    pins(1'b0, 1'b1, "R7 group 0 on fiq");
    rd(5'd18, 32'd1, "R7 ack group 0");
    idle(2);
    pins(1'b0, 1'b0, "R7 fiq drops after ack");
    wr(5'd19, 32'd1);
    wr(5'd4, 32'h00000002);
    wr(5'd3, 32'h00000002);
    idle(2);
    pins(1'b1, 1'b0, "R7 group 1 on irq");
    wr(5'd0, 32'h1);
    idle(2);
    pins(1'b0, 1'b0, "R7 group 1 disabled");
    rd(5'd18, NONE, "R7 disabled group not acked");
    wr(5'd0, 32'h3);
    idle(2);
    pins(1'b1, 1'b0, "R7 group 1 re-enabled");
    rd(5'd18, 32'd1, "R7 ack group 1");
    wr(5'd19, 32'd1);
    wr(5'd4, 32'h0);

    // R8 edge line 1 -> ID 17
    wr(5'd5, 32'h5555555D);
    wr(5'd1, 32'h00020000);
    @(negedge clk); irq_lines[1] = 1'b1;
    idle(4);
    pins(1'b0, 1'b1, "R8 rising edge pends");
    rd(5'd18, 32'd17, "R8 ack edge id");
    wr(5'd19, 32'd17);
    idle(4);
    pins(1'b0, 1'b0, "R8 held line no repend");
    rd(5'd18, NONE, "R8 no repend");
    irq_lines[1] = 1'b0;

    // R9 level line 2 -> ID 18
    wr(5'd1, 32'h00040000);
    @(negedge clk); irq_lines[2] = 1'b1;
    idle(4);
    rd(5'd18, 32'd18, "R9 level pends");
    wr(5'd19, 32'd18);
    rd(5'd18, 32'd18, "R9 level repends");
    wr(5'd19, 32'd18);
    irq_lines[2] = 1'b0;
    idle(4);
    rd(5'd18, NONE, "R9 line low");

    // R10 preemption split
    wr(5'd8, 32'h80C08080);
    wr(5'd9, 32'h80808080);
    wr(5'd17, 32'd6);
    wr(5'd3, 32'h00000004);
    rd(5'd18, 32'd2, "R10 first active");
    wr(5'd3, 32'h00000040);
    rd(5'd18, NONE, "R10 same group no preempt");
    wr(5'd17, 32'd5);
    rd(5'd18, 32'd6, "R10 finer split preempts");
    wr(5'd19, 32'd6);
    wr(5'd19, 32'd2);

    // R11 preemption off
    wr(5'd17, 32'd7);
    wr(5'd3, 32'h00000004);
    rd(5'd18, 32'd2, "R11 first active");
    wr(5'd3, 32'h00000040);
    rd(5'd18, NONE, "R11 no preemption");
    wr(5'd19, 32'd2);
    rd(5'd18, 32'd6, "R11 after end of interrupt");
    wr(5'd19, 32'd6);
    rd(5'd18, NONE, "R12 all idle");

    idle(4);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule